// File: doc/BRIEF.md
# Masked Interrupt Event Aggregator

This block collects single-cycle event pulses from up to 96 peripheral sources and keeps them in three 32-bit sticky status words. Software acknowledges an event by writing a one to its status bit. Writing a zero to a bit leaves that bit as it is.

Three independent mask groups each cover the whole 96-bit status. Each group drives its own registered, level-sensitive interrupt line. Line 0 is the highest-priority line and line 2 the lowest.

For each line there is a read-only vector word. It names the lowest-numbered event that is both pending and enabled for that line, so the handler does not have to scan the status words itself. All registers sit on a simple word-addressed bus: a write strobe, a byte address and a combinational read.

Top module: `evt_aggregator`

## Requirements
- R1: A pulse on `evt_pulse[n]` sets bit n%32 of status word n/32 on the next clock edge. The status words are at byte offsets 0x00, 0x04 and 0x08. The bit stays set until it is acknowledged.
- R2: A bus write to a status word clears every bit written as one. Bits written as zero keep their value.
- R3: When an event pulse and a clearing write to the same bit arrive in the same cycle, the bit ends up set.
- R4: Mask word w of group g is readable and writable at offset 0x10 + 0x10*g + 4*w. Group 0 is at 0x10–0x18, group 1 at 0x20–0x28 and group 2 at 0x30–0x38.
- R5: `irq[g]` is registered. It goes high one clock after the AND of the status with group g's mask becomes nonzero, and low one clock after that AND becomes zero.
- R6: A pending event whose bit is clear in a group's mask never raises that group's line.
- R7: The vector word of line g is at offset 0x40 + 4*g. It returns the lowest pending, enabled event number (0–95) in bits 6:0, with bit 31 set. It returns zero when no event is pending and enabled for that line. Lower status words take priority.
- R8: Writes to status, vector or unmapped offsets leave every mask bit unchanged. Reads of unmapped offsets return zero.
- R9: After reset all status bits, all mask bits and all interrupt lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 96 | One-cycle event pulses, bit n is event n |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 3 | Interrupt lines, index 0 highest priority |

## Verification
The bench builds the block with its defaults: three status words of 32 bits and three lines.

With these values the full register map can be exercised:
- the extreme event numbers 0 and 95;
- a lower word beating a higher bit when the vector is resolved;
- all three lines active at once.

The same values also cover the set-over-clear collision and the unmapped holes between register groups (0x0C, 0x3C, 0x4C). Each of these is observed through bus reads and the `irq` pins.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;

  // Byte offset of status word w.
  function automatic int status_off(input int w);
    return 4 * w;
  endfunction

  // Byte offset of mask word w in group g.
  function automatic int mask_off(input int g, input int w);
    return 16 * (g + 1) + 4 * w;
  endfunction

  // Byte offset of the vector word of line l.
  function automatic int vec_off(input int l);
    return 64 + 4 * l;
  endfunction

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int NUM_EVT = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] status_o
);
  logic [NUM_EVT-1:0] st_q;

  // Clear is applied first, then set, so a set in the same cycle wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr_i) | set_i;
  end

  assign status_o = st_q;
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank
  import evt_agg_pkg::*;
#(
  parameter int NUM_LINES = 3,
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int NUM_EVT  = NUM_WORDS * WORD_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [WORD_W-1:0]                 wdata,
  output logic [NUM_LINES-1:0][NUM_EVT-1:0] mask_o,
  output logic                              hit_o
);
  logic [NUM_LINES*NUM_WORDS-1:0] sel;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_grp
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] m_q;

      assign sel[g*NUM_WORDS+w] = (int'(addr) == mask_off(g, w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             m_q <= '0;
        else if (wr_en && sel[g*NUM_WORDS+w])   m_q <= wdata;
      end

      assign mask_o[g][w*WORD_W +: WORD_W] = m_q;
    end
  end

  assign hit_o = wr_en && (|sel);
endmodule

// File: rtl/evt_lowest_enc.sv
module evt_lowest_enc #(
  parameter int NUM_EVT = 96,
  localparam int IDX_W  = $clog2(NUM_EVT)
) (
  input  logic [NUM_EVT-1:0] vec_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  // Scan from the top bit down, so the last hit is the lowest set bit.
  function automatic logic [IDX_W-1:0] lowest(input logic [NUM_EVT-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign valid_o = |vec_i;
  assign idx_o   = lowest(vec_i);
endmodule

// File: rtl/evt_aggregator.sv
module evt_aggregator
  import evt_agg_pkg::*;
#(
  parameter int NUM_LINES = 3,
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int NUM_EVT  = NUM_WORDS * WORD_W,
  localparam int IDX_W    = $clog2(NUM_EVT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   evt_pulse,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq
);
  // Named internal events, brought out for the checker.
  logic [NUM_EVT-1:0]                status_flat;
  logic [NUM_EVT-1:0]                ack_clr;
  logic [NUM_LINES-1:0][NUM_EVT-1:0] mask_flat;
  logic [NUM_LINES-1:0][NUM_EVT-1:0] masked_flat;
  logic                              mask_wr;
  logic [NUM_LINES-1:0]              vec_valid;
  logic [NUM_LINES-1:0][IDX_W-1:0]   vec_num;
  logic [NUM_LINES-1:0]              irq_q;

  // Acknowledge decode: each status word has its own write-one-to-clear strobe.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_ack
    assign ack_clr[w*WORD_W +: WORD_W] =
      (bus_wr && int'(bus_addr) == status_off(w)) ? bus_wdata : '0;
  end

  evt_status_bank #(.NUM_EVT(NUM_EVT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_pulse),
    .clr_i    (ack_clr),
    .status_o (status_flat)
  );

  evt_mask_bank #(
    .NUM_LINES (NUM_LINES),
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W)
  ) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .mask_o (mask_flat),
    .hit_o  (mask_wr)
  );

  // Per-line masking, vector resolution and the registered request line.
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign masked_flat[l] = status_flat & mask_flat[l];

    evt_lowest_enc #(.NUM_EVT(NUM_EVT)) u_enc (
      .vec_i   (masked_flat[l]),
      .valid_o (vec_valid[l]),
      .idx_o   (vec_num[l])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[l] <= 1'b0;
      else        irq_q[l] <= |masked_flat[l];
    end
  end

  assign irq = irq_q;

  // Read multiplexer: unmapped offsets fall through to zero.
  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (int'(bus_addr) == status_off(w))
        bus_rdata = status_flat[w*WORD_W +: WORD_W];
    for (int g = 0; g < NUM_LINES; g++)
      for (int w = 0; w < NUM_WORDS; w++)
        if (int'(bus_addr) == mask_off(g, w))
          bus_rdata = mask_flat[g][w*WORD_W +: WORD_W];
    for (int l = 0; l < NUM_LINES; l++)
      if (int'(bus_addr) == vec_off(l)) begin
        bus_rdata                = '0;
        bus_rdata[WORD_W-1]      = vec_valid[l];
        bus_rdata[IDX_W-1:0]     = vec_valid[l] ? vec_num[l] : '0;
      end
  end
endmodule

// File: rtl/evt_aggregator_chk.sv
module evt_aggregator_chk #(
  parameter int NUM_LINES = 3,
  parameter int NUM_EVT   = 96,
  parameter int IDX_W     = 7
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_EVT-1:0]                evt_pulse,
  input logic [NUM_EVT-1:0]                status_flat,
  input logic [NUM_EVT-1:0]                ack_clr,
  input logic [NUM_LINES-1:0][NUM_EVT-1:0] mask_flat,
  input logic [NUM_LINES-1:0][NUM_EVT-1:0] masked_flat,
  input logic                              mask_wr,
  input logic [NUM_LINES-1:0]              vec_valid,
  input logic [NUM_LINES-1:0][IDX_W-1:0]   vec_num,
  input logic [NUM_LINES-1:0]              irq
);
  // R1 and R3: every pulsed event is pending one cycle later, even when a clear hit the same bit.
  p_evt_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((status_flat & $past(evt_pulse)) == $past(evt_pulse)));

  // R2: a clear with no competing pulse removes the bits written as one.
  p_ack_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_clr != '0) && (evt_pulse == '0)) |=> ((status_flat & $past(ack_clr)) == '0));

  // R8: mask state moves only on a mask write.
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_flat));

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
    // R5: the line follows the masked status with one cycle of lag.
    p_irq_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq[l] == $past(|masked_flat[l])));

    // R6: a group with no enabled bit cannot raise its line.
    p_no_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_flat[l] == '0) |=> !irq[l]);

    // R7: a valid vector names a bit that is pending and enabled.
    p_vec_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid[l] |-> masked_flat[l][vec_num[l]]);
  end
endmodule

bind evt_aggregator evt_aggregator_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_EVT   (NUM_EVT),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_pulse   (evt_pulse),
  .status_flat (status_flat),
  .ack_clr     (ack_clr),
  .mask_flat   (mask_flat),
  .masked_flat (masked_flat),
  .mask_wr     (mask_wr),
  .vec_valid   (vec_valid),
  .vec_num     (vec_num),
  .irq         (irq)
);

// File: tb/evt_aggregator_bench.sv
module evt_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt_pulse = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  evt_aggregator u_evt_aggregator (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // Monitor: one expected item per falling edge, compared against the ports.
  always @(negedge clk) begin
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      n_tests++;
      if (it.is_irq) begin
        if (irq !== it.exp[2:0]) begin
          n_fail++;
          $display("FAIL %s irq: got %b expected %b", it.tag, irq, it.exp[2:0]);
        end
      end else if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s read @%h: got %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
      end
    end
  end

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    q.push_back('{1'b0, a, e, tag});
  endtask

  task automatic exp_irq(input logic [2:0] e, input string tag);
    @(posedge clk); #1;
    q.push_back('{1'b1, 8'h00, {29'd0, e}, tag});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [95:0] e);
    @(posedge clk); #1;
    evt_pulse = e;
    @(posedge clk); #1;
    evt_pulse = '0;
  endtask

  // A pulse and a clearing write to the same bit in one cycle.
  task automatic pulse_and_clear(input logic [95:0] e, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    evt_pulse = e; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    evt_pulse = '0; bus_wr = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset state
    exp_rd(8'h00, 32'h0, "R9 status0");
    exp_rd(8'h08, 32'h0, "R9 status2");
    exp_rd(8'h10, 32'h0, "R9 mask g0w0");
    exp_rd(8'h38, 32'h0, "R9 mask g2w2");
    exp_irq(3'b000, "R9 irq");

    // R1, R6: an event with no mask is latched but raises nothing
    pulse(96'd1 << 5);
    exp_rd(8'h00, 32'h20, "R1 event5 latched");
    exp_rd(8'h00, 32'h20, "R1 event5 sticky");
    exp_irq(3'b000, "R6 unmasked no irq");
    exp_rd(8'h40, 32'h0, "R7 vector empty");

    // R4, R5, R7: enable event 5 on line 0
    wr(8'h10, 32'h20);
    exp_irq(3'b001, "R5 line0 raised");
    exp_rd(8'h10, 32'h20, "R4 mask readback");
    exp_rd(8'h40, 32'h8000_0005, "R7 vector0 event5");

    // Two words at once, line 1 takes event 40
    pulse((96'd1 << 3) | (96'd1 << 40));
    wr(8'h10, 32'h28);
    wr(8'h24, 32'h100);
    exp_rd(8'h00, 32'h28, "R1 status0");
    exp_rd(8'h04, 32'h100, "R1 status1 event40");
    exp_rd(8'h40, 32'h8000_0003, "R7 vector0 lowest");
    exp_rd(8'h44, 32'h8000_0028, "R7 vector1 event40");
    exp_irq(3'b011, "R5 lines 0 and 1");

    // Top event on line 2
    pulse(96'd1 << 95);
    wr(8'h38, 32'h8000_0000);
    exp_rd(8'h08, 32'h8000_0000, "R1 status2 event95");
    exp_rd(8'h48, 32'h8000_005F, "R7 vector2 event95");
    exp_irq(3'b111, "R5 all lines");

    // R7: the lower word wins over a higher bit
    wr(8'h30, 32'h20);
    exp_rd(8'h48, 32'h8000_0005, "R7 lower word priority");
    exp_rd(8'h38, 32'h8000_0000, "R4 mask g2w2 kept");

    // R2: acknowledge only bit 3
    wr(8'h00, 32'h08);
    exp_rd(8'h00, 32'h20, "R2 only written bit cleared");
    exp_rd(8'h04, 32'h100, "R2 other word untouched");
    exp_rd(8'h40, 32'h8000_0005, "R2 vector0 after ack");

    // R3: set beats clear in the same cycle
    pulse_and_clear(96'd1 << 5, 8'h00, 32'h20);
    exp_rd(8'h00, 32'h20, "R3 set wins");

    // R2, R5: clearing event 40 drops line 1
    wr(8'h04, 32'h100);
    exp_rd(8'h04, 32'h0, "R2 status1 cleared");
    exp_rd(8'h44, 32'h0, "R7 vector1 empty");
    exp_irq(3'b101, "R5 line1 dropped");

    // R8: writes to vector, unmapped and status offsets leave masks alone
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0);
    exp_rd(8'h10, 32'h28, "R8 mask g0w0 held");
    exp_rd(8'h24, 32'h100, "R8 mask g1w1 held");
    exp_rd(8'h30, 32'h20, "R8 mask g2w0 held");
    exp_rd(8'h38, 32'h8000_0000, "R8 mask g2w2 held");
    exp_rd(8'h00, 32'h20, "R8 status0 held");
    exp_rd(8'h0C, 32'h0, "R8 unmapped 0C");
    exp_rd(8'h3C, 32'h0, "R8 unmapped 3C");
    exp_rd(8'h4C, 32'h0, "R8 unmapped 4C");
    exp_rd(8'h80, 32'h0, "R8 unmapped 80");

    // R6: removing line 0's mask drops it while line 2 stays
    wr(8'h10, 32'h0);
    exp_irq(3'b100, "R6 line0 masked off");

    // R2, R5: clear everything
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    exp_rd(8'h00, 32'h0, "R2 status0 all cleared");
    exp_rd(8'h08, 32'h0, "R2 status2 all cleared");
    exp_rd(8'h48, 32'h0, "R7 vector2 empty");
    exp_irq(3'b000, "R5 all lines low");

    wait (q.size() == 0);
    @(posedge clk); #1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule